// File: doc/BRIEF.md
# Register-Mapped Packet Buffer NIC

This peripheral moves whole Ethernet frames through a small register window, one byte per access. The host uses a simple bus port to read and write 32-bit registers. Frames from the network enter on a byte stream (valid, data, last) and land in a receive buffer. The host drains that buffer one byte per read of a data register. To send, the host loads a transmit byte count and writes the frame one byte at a time into a transmit buffer. When the frame is complete, the block streams it out on an outbound byte stream that honours a ready signal.

A three-bit interrupt-control register drives a level interrupt. The register holds a transmit-complete flag, a receive-complete flag and a self-test flag. A busy flag follows that register and decides whether the next inbound frame is taken in. The host therefore has to clear the completion flags before another frame can arrive. Writing only the self-test bit performs a soft reset of counters and flags and leaves the self-test flag raised. A read of the interrupt-control register clears the self-test flag.

Top module: `pktbuf_nic`

## Requirements
- R1: Only address bits [5:0] select a register. The registers are:
  - 0x00 reads 0x4D495053.
  - 0x04 reads 0x4E455430.
  - 0x08 is busy, in bit 0.
  - 0x0C is the receive count.
  - 0x10 is the transmit count.
  - 0x14 is interrupt control.
  - 0x18 is interrupt info and reads 0.
  - 0x1C is the receive data port.
  - 0x20 is the transmit data port and reads 0.
  - Every other offset reads 0.
  
  Read data appears on `bus_rdata` one clock after the read access.
- R2: Writes to 0x00, 0x04, 0x08, 0x0C, 0x18, 0x1C and to unmapped offsets change nothing.
- R3: A write to the transmit count loads the written value if it is at most MAX_FRAME (1514). Otherwise it loads 0. Either way it restarts the transmit write index at 0.
- R4: A write to the transmit data port stores `bus_wdata[7:0]` and advances the write index. When the index equals the programmed nonzero count, or reaches MAX_FRAME, the frame is sent. Sending has these effects:
  - The stored bytes stream out in order, with `tx_last` on the final byte.
  - Each byte is held stable until `tx_ready` accepts it.
  - The transmit count and index return to 0.
  - TX-done is set.
  - Busy becomes 1.
- R5: The interrupt-control bits are: bit 0 TX-done, bit 1 RX-done, bit 31 self-test. A write is handled in priority order:
  1. If bit 0 is set, only TX-done is cleared.
  2. Otherwise, if bit 1 is set, only RX-done is cleared.
  3. Otherwise, if bit 31 is set, a soft reset is performed.
  4. Otherwise the write changes no flag.
- R6: The soft reset does the following:
  - Clears both counts and all indices.
  - Sets interrupt control to exactly 0x80000000.
  - Discards any inbound frame in progress.
- R7: A read of interrupt control returns the value held before the read. It then clears the self-test bit.
- R8: Busy is 1 after reset. After any write to interrupt control, busy equals (interrupt control != 0). Busy is also set to 1 by a received frame and by a sent frame.
- R9: `irq` is 1 exactly when any interrupt-control bit is set, in the same cycle.
- R10: An inbound frame is accepted only if all of these hold:
  - Busy is 0 and the receive count is below MAX_FRAME, both at its first byte and at its last byte.
  - Its length is below MAX_FRAME.

  On acceptance the receive count becomes the length, the read index restarts at 0, RX-done is set and busy becomes 1.
- R11: A frame that is not accepted is dropped whole. It leaves the receive count and interrupt control unchanged.
- R12: A read of the receive data port while the count is nonzero returns the next byte in arrival order, in bits [7:0], and decrements the count. With a count of 0 it returns 0.
- R13: While the outbound stream is active, writes to the transmit count and transmit data port are ignored.
- R14: After reset:
  - Busy reads 1.
  - Both counts read 0.
  - Interrupt control reads 0.
  - `irq` is 0.
  - `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits [5:0] decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Inbound byte valid |
| rx_data | input | 8 | Inbound byte |
| rx_last | input | 1 | Inbound byte ends the frame |
| tx_valid | output | 1 | Outbound byte valid |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Outbound byte ends the frame |
| tx_ready | input | 1 | Downstream accepts the outbound byte |
| irq | output | 1 | Level interrupt |

## Verification
A corrupt receive count or read index shows up on the next receive-data read. It appears either as a byte out of order or as a nonzero value past the end of the frame. A stuck or mis-set completion flag shows on `irq` in the same cycle. It also shows in the busy register one access later, and then as inbound frames being dropped or wrongly taken in. A wrong transmit index shows only once a frame completes: the outbound stream then starts too early or too late, or `tx_last` falls on the wrong byte. The bench therefore compares every streamed byte and the position of `tx_last`.

// File: rtl/pktbuf_nic_pkg.sv
package pktbuf_nic_pkg;

   localparam int REG_AW = 6;

   localparam logic [REG_AW-1:0] OFS_ID_HI   = 6'h00;
   localparam logic [REG_AW-1:0] OFS_ID_LO   = 6'h04;
   localparam logic [REG_AW-1:0] OFS_BUSY    = 6'h08;
   localparam logic [REG_AW-1:0] OFS_RXCNT   = 6'h0C;
   localparam logic [REG_AW-1:0] OFS_TXCNT   = 6'h10;
   localparam logic [REG_AW-1:0] OFS_IRQCTL  = 6'h14;
   localparam logic [REG_AW-1:0] OFS_IRQINFO = 6'h18;
   localparam logic [REG_AW-1:0] OFS_RXDATA  = 6'h1C;
   localparam logic [REG_AW-1:0] OFS_TXDATA  = 6'h20;

   localparam logic [31:0] ID_WORD_HI = 32'h4D49_5053;
   localparam logic [31:0] ID_WORD_LO = 32'h4E45_5430;

   // interrupt-control word layout (bit positions seen by software)
   localparam int FLAG_TX_POS   = 0;
   localparam int FLAG_RX_POS   = 1;
   localparam int FLAG_TEST_POS = 31;

   typedef struct packed {
      logic test;
      logic rx;
      logic tx;
   } irq_flags_t;

   function automatic logic [31:0] flags_to_word(irq_flags_t f);
      logic [31:0] w;
      w                = '0;
      w[FLAG_TX_POS]   = f.tx;
      w[FLAG_RX_POS]   = f.rx;
      w[FLAG_TEST_POS] = f.test;
      return w;
   endfunction

endpackage

// File: rtl/pktbuf_nic_irqctl.sv
module pktbuf_nic_irqctl
   import pktbuf_nic_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       w_tx,
   input  logic       w_rx,
   input  logic       w_test,
   input  logic       rd,
   input  logic       set_tx,
   input  logic       set_rx,
   output irq_flags_t flags,
   output logic       busy,
   output logic       soft_clr,
   output logic       irq
);

   irq_flags_t flags_nxt;
   logic       busy_nxt;

   assign soft_clr = wr && !w_tx && !w_rx && w_test;

   always_comb begin
      flags_nxt = flags;
      busy_nxt  = busy;
      if (rd) flags_nxt.test = 1'b0;
      if (wr) begin
         if (w_tx)        flags_nxt.tx = 1'b0;
         else if (w_rx)   flags_nxt.rx = 1'b0;
         else if (w_test) flags_nxt    = '{test: 1'b1, rx: 1'b0, tx: 1'b0};
      end
      if (set_tx) flags_nxt.tx = 1'b1;
      if (set_rx) flags_nxt.rx = 1'b1;
      if (wr) busy_nxt = |flags_nxt;
      if (set_tx || set_rx) busy_nxt = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         busy  <= 1'b1;
      end else begin
         flags <= flags_nxt;
         busy  <= busy_nxt;
      end
   end

   assign irq = |flags;

endmodule

// File: rtl/pktbuf_nic_rxbuf.sv
module pktbuf_nic_rxbuf #(
   parameter int MAX_FRAME = 1514,
   parameter int CNT_W     = $clog2(MAX_FRAME + 1),
   parameter int IDX_W     = $clog2(MAX_FRAME)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             rx_last,
   input  logic             gate_open,
   input  logic             soft_clr,
   input  logic             pop,
   output logic [CNT_W-1:0] count,
   output logic [7:0]       rd_byte,
   output logic             commit
);

   localparam logic [CNT_W-1:0] LIM_LEN  = CNT_W'(MAX_FRAME);
   localparam logic [CNT_W-1:0] LIM_LAST = CNT_W'(MAX_FRAME - 1);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   logic [7:0]       mem [MAX_FRAME];
   logic             in_frame;
   logic             taking;
   logic [CNT_W-1:0] wr_len;
   logic [CNT_W-1:0] rd_idx;

   logic [CNT_W-1:0] pos;
   logic             gate;
   logic             take_now;
   logic             store;

   assign pos      = in_frame ? wr_len : '0;
   assign gate     = gate_open && (count < LIM_LEN);
   assign take_now = in_frame ? taking : gate;
   assign store    = rx_valid && take_now && (pos < LIM_LAST);
   assign commit   = store && rx_last && gate && !soft_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         taking   <= 1'b0;
         wr_len   <= '0;
         count    <= '0;
         rd_idx   <= '0;
      end else begin
         if (rx_valid) begin
            in_frame <= !rx_last;
            taking   <= store && !rx_last;
            if (store) wr_len <= pos + ONE;
         end
         if (soft_clr) taking <= 1'b0;

         if (soft_clr) begin
            count  <= '0;
            rd_idx <= '0;
         end else if (commit) begin
            count  <= pos + ONE;
            rd_idx <= '0;
         end else if (pop && (count != '0)) begin
            count  <= count - ONE;
            rd_idx <= rd_idx + ONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (store) mem[pos[IDX_W-1:0]] <= rx_data;
   end

   assign rd_byte = mem[rd_idx[IDX_W-1:0]];

endmodule

// File: rtl/pktbuf_nic_txbuf.sv
module pktbuf_nic_txbuf #(
   parameter int MAX_FRAME = 1514,
   parameter int CNT_W     = $clog2(MAX_FRAME + 1),
   parameter int IDX_W     = $clog2(MAX_FRAME)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_count,
   input  logic [31:0]      count_val,
   input  logic             wr_byte,
   input  logic [7:0]       byte_val,
   input  logic             soft_clr,
   output logic [CNT_W-1:0] count,
   output logic             sent,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_last,
   input  logic             tx_ready
);

   localparam logic [CNT_W-1:0] LIM_LEN = CNT_W'(MAX_FRAME);
   localparam logic [31:0]      LIM_W32 = 32'(MAX_FRAME);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic [7:0]       mem [MAX_FRAME];
   logic             sending;
   logic [CNT_W-1:0] widx;
   logic [CNT_W-1:0] rd_ptr;
   logic [CNT_W-1:0] send_len;
   logic [CNT_W-1:0] nxt;
   logic             accept_wr;

   assign nxt       = widx + ONE;
   assign accept_wr = wr_byte && !sending;
   assign sent      = accept_wr && ((nxt >= LIM_LEN) || (nxt == count));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sending  <= 1'b0;
         widx     <= '0;
         rd_ptr   <= '0;
         send_len <= '0;
         count    <= '0;
      end else begin
         if (soft_clr) begin
            count <= '0;
            widx  <= '0;
         end else if (ld_count && !sending) begin
            count <= (count_val <= LIM_W32) ? count_val[CNT_W-1:0] : '0;
            widx  <= '0;
         end else if (accept_wr) begin
            if (sent) begin
               count    <= '0;
               widx     <= '0;
               send_len <= nxt;
               rd_ptr   <= '0;
               sending  <= 1'b1;
            end else begin
               widx <= nxt;
            end
         end
         if (sending && tx_ready) begin
            if (tx_last) sending <= 1'b0;
            else         rd_ptr  <= rd_ptr + ONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept_wr) mem[widx[IDX_W-1:0]] <= byte_val;
   end

   assign tx_valid = sending;
   assign tx_data  = mem[rd_ptr[IDX_W-1:0]];
   assign tx_last  = sending && (rd_ptr == send_len - ONE);

endmodule

// File: rtl/pktbuf_nic.sv
module pktbuf_nic
   import pktbuf_nic_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int MAX_FRAME = 1514
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_last,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              irq
);

   localparam int CNT_W = $clog2(MAX_FRAME + 1);
   localparam int IDX_W = $clog2(MAX_FRAME);

   if (ADDR_W < REG_AW) begin : g_bad_addr
      $error("pktbuf_nic: ADDR_W must cover the 6-bit register window");
   end
   if (MAX_FRAME < 2 || MAX_FRAME > 65535) begin : g_bad_frame
      $error("pktbuf_nic: MAX_FRAME out of range");
   end

   logic [REG_AW-1:0] ofs;
   assign ofs = bus_addr[REG_AW-1:0];

   if (ADDR_W > REG_AW) begin : g_addr_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^bus_addr[ADDR_W-1:REG_AW];
   end

   logic rd_en, wr_en;
   assign rd_en = bus_sel && !bus_we;
   assign wr_en = bus_sel && bus_we;

   logic wr_txcnt, wr_txdat, wr_irq, rd_irq, rd_rxdat;
   assign wr_txcnt = wr_en && (ofs == OFS_TXCNT);
   assign wr_txdat = wr_en && (ofs == OFS_TXDATA);
   assign wr_irq   = wr_en && (ofs == OFS_IRQCTL);
   assign rd_irq   = rd_en && (ofs == OFS_IRQCTL);
   assign rd_rxdat = rd_en && (ofs == OFS_RXDATA);

   irq_flags_t       flags;
   logic             busy;
   logic             soft_clr;
   logic             rx_commit;
   logic             tx_sent;
   logic [CNT_W-1:0] rx_count;
   logic [CNT_W-1:0] tx_count;
   logic [7:0]       rx_byte;
   logic [31:0]      irq_word;

   assign irq_word = flags_to_word(flags);

   pktbuf_nic_irqctl u_irqctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_irq),
      .w_tx     (bus_wdata[FLAG_TX_POS]),
      .w_rx     (bus_wdata[FLAG_RX_POS]),
      .w_test   (bus_wdata[FLAG_TEST_POS]),
      .rd       (rd_irq),
      .set_tx   (tx_sent),
      .set_rx   (rx_commit),
      .flags    (flags),
      .busy     (busy),
      .soft_clr (soft_clr),
      .irq      (irq)
   );

   pktbuf_nic_rxbuf #(
      .MAX_FRAME (MAX_FRAME),
      .CNT_W     (CNT_W),
      .IDX_W     (IDX_W)
   ) u_rxbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_last   (rx_last),
      .gate_open (!busy),
      .soft_clr  (soft_clr),
      .pop       (rd_rxdat),
      .count     (rx_count),
      .rd_byte   (rx_byte),
      .commit    (rx_commit)
   );

   pktbuf_nic_txbuf #(
      .MAX_FRAME (MAX_FRAME),
      .CNT_W     (CNT_W),
      .IDX_W     (IDX_W)
   ) u_txbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_count  (wr_txcnt),
      .count_val (bus_wdata),
      .wr_byte   (wr_txdat),
      .byte_val  (bus_wdata[7:0]),
      .soft_clr  (soft_clr),
      .count     (tx_count),
      .sent      (tx_sent),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_last   (tx_last),
      .tx_ready  (tx_ready)
   );

   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      unique case (ofs)
         OFS_ID_HI:  rd_mux = ID_WORD_HI;
         OFS_ID_LO:  rd_mux = ID_WORD_LO;
         OFS_BUSY:   rd_mux = {31'd0, busy};
         OFS_RXCNT:  rd_mux = {{(32-CNT_W){1'b0}}, rx_count};
         OFS_TXCNT:  rd_mux = {{(32-CNT_W){1'b0}}, tx_count};
         OFS_IRQCTL: rd_mux = irq_word;
         OFS_RXDATA: rd_mux = (rx_count != '0) ? {24'd0, rx_byte} : '0;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= rd_mux;
   end

endmodule

// File: rtl/pktbuf_nic_chk.sv
module pktbuf_nic_chk #(
   parameter int MAX_FRAME = 1514,
   parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_irq,
   input logic             rd_rxdat,
   input logic             wr_irq,
   input logic [31:0]      bus_wdata,
   input logic [CNT_W-1:0] rx_count,
   input logic [CNT_W-1:0] tx_count,
   input logic             rx_commit,
   input logic [31:0]      irq_word,
   input logic             busy,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic [7:0]       tx_data,
   input logic             tx_last
);

   assert_rx_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count < CNT_W'(MAX_FRAME));

   assert_tx_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= CNT_W'(MAX_FRAME));

   assert_busy_on_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_commit |=> busy && irq_word[1]);

   assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last));

   assert_test_clear_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_irq |=> !irq_word[31]);

   assert_rx_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rxdat && rx_count != '0 && !rx_commit) |=> rx_count == $past(rx_count) - CNT_W'(1));

   assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_irq && bus_wdata == 32'h8000_0000) |=>
         (rx_count == '0 && tx_count == '0 && irq_word == 32'h8000_0000));

endmodule

bind pktbuf_nic pktbuf_nic_chk #(
   .MAX_FRAME (MAX_FRAME),
   .CNT_W     (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_irq    (rd_irq),
   .rd_rxdat  (rd_rxdat),
   .wr_irq    (wr_irq),
   .bus_wdata (bus_wdata),
   .rx_count  (rx_count),
   .tx_count  (tx_count),
   .rx_commit (rx_commit),
   .irq_word  (irq_word),
   .busy      (busy),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_data   (tx_data),
   .tx_last   (tx_last)
);

// File: tb/test_pktbuf_nic.sv
`timescale 1ns/1ps
module test_pktbuf_nic;

   localparam int ADDR_W = 8;
   localparam int MAXF   = 1514;

   localparam logic [7:0] A_ID0 = 8'h00, A_ID1 = 8'h04, A_BUSY = 8'h08, A_RXC = 8'h0C,
                          A_TXC = 8'h10, A_IRQ = 8'h14, A_INFO = 8'h18, A_RXD = 8'h1C,
                          A_TXD = 8'h20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0, bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              rx_valid = 1'b0, rx_last = 1'b0;
   logic [7:0]        rx_data = '0;
   logic              tx_valid, tx_last;
   logic [7:0]        tx_data;
   logic              tx_ready = 1'b1;
   logic              irq;

   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   pktbuf_nic #(.ADDR_W(ADDR_W), .MAX_FRAME(MAXF)) i_pktbuf_nic (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_last(rx_last), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .tx_ready(tx_ready), .irq(irq)
   );

   // expected values
   function automatic logic [31:0] exp_txcnt(input logic [31:0] v);
      return (v <= 32'(MAXF)) ? v : 32'd0;
   endfunction

   function automatic logic [31:0] exp_flags(input bit t, input bit r, input bit s);
      return {s, 29'd0, r, t};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_rd(a, d);
      chk(req, d, exp);
   endtask

   // inbound frame driver
   logic [7:0] rx_exp [0:2047];

   task automatic rx_send(input int len, input bit fresh);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (fresh) rx_exp[i] = 8'($urandom);
         rx_valid = 1'b1;
         rx_data  = fresh ? rx_exp[i] : 8'(i ^ 8'h5A);
         rx_last  = (i == len - 1);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
   endtask

   task automatic rx_drain(input string req, input int len);
      for (int i = 0; i < len; i++) rd_chk(req, A_RXD, {24'd0, rx_exp[i]});
   endtask

   // outbound monitor and ready driver
   logic [7:0] cap [0:2047];
   logic [7:0] tx_exp [0:2047];
   int  cap_n = 0, n_last = 0, last_at = -1;
   bit  rdy_rand = 1'b1, rdy_val = 1'b1;

   always @(posedge clk) begin
      #2;
      tx_ready <= rdy_rand ? 1'($urandom % 2) : rdy_val;
   end

   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready && cap_n < 2048) begin
         cap[cap_n] = tx_data;
         if (tx_last) begin n_last++; last_at = cap_n; end
         cap_n++;
      end
   end

   task automatic tx_load(input int n, input logic [31:0] cnt);
      cap_n = 0; n_last = 0; last_at = -1;
      bus_wr(A_TXC, cnt);
      for (int i = 0; i < n; i++) begin
         tx_exp[i] = 8'($urandom);
         bus_wr(A_TXD, {24'($urandom), tx_exp[i]});
      end
   endtask

   task automatic tx_wait(input string req, input int n);
      int bad = 0;
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         if (cap_n >= n && !tx_valid) break;
      end
      chk(req, 32'(cap_n), 32'(n));
      for (int i = 0; i < n; i++) if (cap[i] !== tx_exp[i]) bad++;
      chk(req, 32'(bad), 32'd0);
      chk(req, 32'(last_at), 32'(n - 1));
      chk(req, 32'(n_last), 32'd1);
   endtask

   // watchdog
   initial begin
      #1_900_000;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int len, n;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R14 reset state
      chk("R14 irq", {31'd0, irq}, 32'd0);
      chk("R14 tx_valid", {31'd0, tx_valid}, 32'd0);
      rd_chk("R14 busy", A_BUSY, 32'd1);
      rd_chk("R14 rxcnt", A_RXC, 32'd0);
      rd_chk("R14 txcnt", A_TXC, 32'd0);
      rd_chk("R14 irqctl", A_IRQ, 32'd0);

      // R1 decode
      rd_chk("R1 id0", A_ID0, 32'h4D49_5053);
      rd_chk("R1 id1", A_ID1, 32'h4E45_5430);
      rd_chk("R1 alias", 8'h40, 32'h4D49_5053);
      rd_chk("R1 alias2", 8'hC4, 32'h4E45_5430);
      rd_chk("R1 info", A_INFO, 32'd0);
      rd_chk("R1 txdata", A_TXD, 32'd0);
      rd_chk("R1 unmapped", 8'h3C, 32'd0);

      // R2 read-only writes
      bus_wr(A_BUSY, 32'd0);
      bus_wr(A_RXC, 32'd5);
      bus_wr(A_ID0, 32'd0);
      rd_chk("R2 busy kept", A_BUSY, 32'd1);
      rd_chk("R2 rxcnt kept", A_RXC, 32'd0);
      rd_chk("R2 id kept", A_ID0, 32'h4D49_5053);

      // R10/R11 dropped while busy after reset
      rx_send(10, 1'b0);
      rd_chk("R11 busy drop cnt", A_RXC, 32'd0);
      rd_chk("R11 busy drop irq", A_IRQ, 32'd0);

      // R8 busy follows write
      bus_wr(A_IRQ, 32'd0);
      rd_chk("R8 busy cleared", A_BUSY, 32'd0);

      // R10 accept
      len = 1 + int'($urandom % 60);
      rx_send(len, 1'b1);
      chk("R9 irq on rx", {31'd0, irq}, 32'd1);
      rd_chk("R10 rxcnt", A_RXC, 32'(len));
      rd_chk("R10 irqctl", A_IRQ, exp_flags(0, 1, 0));
      rd_chk("R8 busy rx", A_BUSY, 32'd1);

      // R11 second frame dropped
      rx_send(5, 1'b0);
      rd_chk("R11 kept cnt", A_RXC, 32'(len));

      // R12 drain
      rx_drain("R12 byte", len);
      rd_chk("R12 empty", A_RXD, 32'd0);
      rd_chk("R12 cnt0", A_RXC, 32'd0);

      // R5 clear rx-done
      bus_wr(A_IRQ, 32'd2);
      rd_chk("R5 clr rx", A_IRQ, 32'd0);
      chk("R9 irq low", {31'd0, irq}, 32'd0);
      rd_chk("R8 busy 0", A_BUSY, 32'd0);

      // R10 length boundary
      rx_send(MAXF, 1'b0);
      rd_chk("R10 long dropped cnt", A_RXC, 32'd0);
      rd_chk("R10 long dropped irq", A_IRQ, 32'd0);
      rx_send(MAXF - 1, 1'b1);
      rd_chk("R10 max-1 cnt", A_RXC, 32'(MAXF - 1));
      rx_drain("R12 long byte", MAXF - 1);
      bus_wr(A_IRQ, 32'd2);

      // R3 transmit count loads
      bus_wr(A_TXC, 32'd2000);
      rd_chk("R3 over", A_TXC, exp_txcnt(32'd2000));
      bus_wr(A_TXC, 32'(MAXF));
      rd_chk("R3 max", A_TXC, exp_txcnt(32'(MAXF)));
      bus_wr(A_TXC, 32'd7);
      rd_chk("R3 seven", A_TXC, exp_txcnt(32'd7));

      // R4 send
      n = 2 + int'($urandom % 40);
      tx_load(n, 32'(n));
      tx_wait("R4 frame", n);
      rd_chk("R4 txdone", A_IRQ, exp_flags(1, 0, 0));
      rd_chk("R4 busy", A_BUSY, 32'd1);
      rd_chk("R4 cnt0", A_TXC, 32'd0);

      // R5 priority
      bus_wr(A_IRQ, 32'd1);
      rx_send(3, 1'b1);
      tx_load(4, 32'd4);
      tx_wait("R4 frame4", 4);
      rd_chk("R5 both", A_IRQ, exp_flags(1, 1, 0));
      bus_wr(A_IRQ, 32'd3);
      rd_chk("R5 tx first", A_IRQ, exp_flags(0, 1, 0));
      bus_wr(A_IRQ, 32'h8000_0002);
      rd_chk("R5 rx before test", A_IRQ, 32'd0);
      rd_chk("R5 no reset", A_RXC, 32'd3);

      // R6/R7 soft reset and clear-on-read
      bus_wr(A_TXC, 32'd9);
      bus_wr(A_IRQ, 32'h8000_0000);
      chk("R9 irq test", {31'd0, irq}, 32'd1);
      rd_chk("R6 rxcnt", A_RXC, 32'd0);
      rd_chk("R6 txcnt", A_TXC, 32'd0);
      rd_chk("R7 first read", A_IRQ, exp_flags(0, 0, 1));
      rd_chk("R7 second read", A_IRQ, 32'd0);
      chk("R9 irq after read", {31'd0, irq}, 32'd0);
      rd_chk("R8 busy after test", A_BUSY, 32'd1);
      bus_wr(A_IRQ, 32'd0);
      rd_chk("R8 busy released", A_BUSY, 32'd0);

      // R4 limit with count 0
      tx_load(MAXF, 32'd0);
      tx_wait("R4 max frame", MAXF);
      bus_wr(A_IRQ, 32'd1);

      // R13 writes ignored while streaming
      rdy_rand = 1'b0; rdy_val = 1'b0;
      tx_load(3, 32'd3);
      bus_wr(A_TXC, 32'd5);
      bus_wr(A_TXD, 32'h0000_00EE);
      rd_chk("R13 txcnt ignored", A_TXC, 32'd0);
      rdy_rand = 1'b1;
      tx_wait("R13 frame intact", 3);
      bus_wr(A_IRQ, 32'd1);

      // random rounds
      for (int r = 0; r < 6; r++) begin
         len = 1 + int'($urandom % 200);
         rx_send(len, 1'b1);
         rd_chk("R10 rand cnt", A_RXC, 32'(len));
         rx_drain("R12 rand byte", len);
         bus_wr(A_IRQ, 32'd2);
         n = 1 + int'($urandom % 200);
         tx_load(n, 32'(n));
         tx_wait("R4 rand frame", n);
         rd_chk("R4 rand txdone", A_IRQ, exp_flags(1, 0, 0));
         bus_wr(A_IRQ, 32'd1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule